// File: doc/BRIEF.md
# Three-Step Combination Lock Controller

The block is a clocked controller for a keypad lock. It keeps three secret code digits, each four bits wide, in separate registers that are written one at a time. A user enters a digit on `value_i` and marks it with a one-cycle `new_i` strobe. The controller walks through three check steps. At each step one shared equality comparator tests the entered digit against the stored digit for that step, and the current step selects that digit through a multiplexer.

If all three digits match in order, the lock opens. Any wrong digit sends the controller into an error state. The error state ignores all further input until reset, so a partly correct guess cannot be finished later. The open state is also held until reset. The lock output comes from a register, so it changes only at a clock edge and has no combinational path from any input.

Digit entry has no back-pressure. Every cycle with `new_i` high is taken as exactly one entered digit, and there is no ready signal. A cycle with `new_i` low is not an entry. Reset is synchronous and active high. It does not clear the code registers.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a clock edge, the controller returns to the first check step and `open_o` reads 0 after that edge. The stored code digits keep their values through reset.
- R2: In check step k (k = 0, 1, 2), a cycle with `new_i`=1 and `value_i` equal to code digit k moves to step k+1. A match at step 2 opens the lock, and `open_o` reads 1 after that edge.
- R3: In any check step, a cycle with `new_i`=1 and `value_i` different from the digit for that step moves to the error state, and `open_o` stays 0.
- R4: A cycle with `new_i`=0 leaves the step, mode and `open_o` unchanged, whatever `value_i` holds.
- R5: Once open, the lock stays open under any further entries until reset.
- R6: Once in the error state, the lock stays closed under any entries, including the correct code, until reset.
- R7: Bit k of `load_en_i` writes `code_i` into code digit k at the clock edge and leaves the other digits unchanged. A digit that is entered in the same cycle as a write to its own register is compared against the old contents.
- R8: `open_o` is driven from a register. Changes on the inputs between clock edges never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| new_i | input | 1 | One-cycle strobe that marks an entered digit |
| value_i | input | 4 | Entered digit |
| load_en_i | input | 3 | Per-digit write enable for the code registers |
| code_i | input | 4 | Data written into the enabled code digit |
| open_o | output | 1 | 1 when the lock is open |

## Verification
The case hardest to reach from the ports is a code register being rewritten in the same cycle that its own digit is entered. The stimulus sets up this collision at step 0. It then shows that the comparison used the old digit and that the new digit is in place after a reset. The bench also probes `open_o` right after the inputs that complete the code are driven, before the clock edge, to show that the output does not follow the inputs. It checks both absorbing states by entering digits after the lock has opened or failed, including the full correct code after a failure.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  typedef enum logic [1:0] {
    M_CHECK = 2'd0,
    M_OPEN  = 2'd1,
    M_ERR   = 2'd2
  } lock_mode_t;
endpackage

// File: rtl/combo_code_bank.sv
module combo_code_bank #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 3,
  localparam int IDX_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk,
  input  logic [NUM_DIGITS-1:0] load_en_i,
  input  logic [DIGIT_W-1:0]    code_i,
  input  logic [IDX_W-1:0]      sel_idx_i,
  output logic [DIGIT_W-1:0]    sel_digit_o
);
  logic [DIGIT_W-1:0] digit_q [NUM_DIGITS];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    always_ff @(posedge clk) begin
      if (load_en_i[g]) digit_q[g] <= code_i;
    end

    // R7: an enabled digit holds the written data after the edge
    a_r7_digit_load: assert property (@(posedge clk)
      load_en_i[g] |=> digit_q[g] == $past(code_i));
    // R7: a digit whose enable is low keeps its contents
    a_r7_digit_keep: assert property (@(posedge clk)
      !load_en_i[g] |=> $stable(digit_q[g]));
  end

  always_comb begin
    sel_digit_o = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (sel_idx_i == IDX_W'(i)) sel_digit_o = digit_q[i];
    end
  end
endmodule

// File: rtl/combo_step_fsm.sv
module combo_step_fsm
  import combo_lock_pkg::*;
#(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 3,
  localparam int IDX_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               new_i,
  input  logic [DIGIT_W-1:0] value_i,
  input  logic [DIGIT_W-1:0] sel_digit_i,
  output logic [IDX_W-1:0]   step_o,
  output logic               open_o
);
  lock_mode_t       mode_q, mode_n;
  logic [IDX_W-1:0] step_q, step_n;
  logic             open_q;
  logic             hit;

  assign hit = (value_i == sel_digit_i);

  always_comb begin
    mode_n = mode_q;
    step_n = step_q;
    if (mode_q == M_CHECK && new_i) begin
      if (!hit)                    mode_n = M_ERR;
      else if (step_q == LAST_IDX) mode_n = M_OPEN;
      else                         step_n = step_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_CHECK;
      step_q <= '0;
      open_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      step_q <= step_n;
      open_q <= (mode_n == M_OPEN);
    end
  end

  assign step_o = step_q;
  assign open_o = open_q;

  // R1: reset puts the machine at step 0, closed
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!open_q && step_q == '0 && mode_q == M_CHECK));
  // R3: a wrong strobed digit during checking leads to the error state
  a_r3_miss_to_err: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_CHECK && new_i && value_i != sel_digit_i) |=> (mode_q == M_ERR && !open_q));
  // R4: no strobe, no movement
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !new_i |=> ($stable(step_q) && $stable(mode_q) && $stable(open_q)));
  // R2: opening needs a strobe at the last step
  a_r2_open_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(open_q) |-> ($past(new_i) && $past(step_q) == LAST_IDX));
  // R5: open is absorbing
  a_r5_open_sticky: assert property (@(posedge clk) disable iff (rst)
    open_q |=> open_q);
  // R6: error is absorbing and closed
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    mode_q == M_ERR |=> (mode_q == M_ERR && !open_q));
endmodule

// File: rtl/combo_lock.sv
module combo_lock #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 3,
  localparam int IDX_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  new_i,
  input  logic [DIGIT_W-1:0]    value_i,
  input  logic [NUM_DIGITS-1:0] load_en_i,
  input  logic [DIGIT_W-1:0]    code_i,
  output logic                  open_o
);
  logic [IDX_W-1:0]   step;
  logic [DIGIT_W-1:0] sel_digit;

  combo_code_bank #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_bank (
    .clk         (clk),
    .load_en_i   (load_en_i),
    .code_i      (code_i),
    .sel_idx_i   (step),
    .sel_digit_o (sel_digit)
  );

  combo_step_fsm #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .new_i       (new_i),
    .value_i     (value_i),
    .sel_digit_i (sel_digit),
    .step_o      (step),
    .open_o      (open_o)
  );
endmodule

// File: tb/combo_lock_test.sv
module combo_lock_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       new_i = 1'b0;
  logic [3:0] value_i = '0;
  logic [2:0] load_en_i = '0;
  logic [3:0] code_i = '0;
  logic       open_o;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  combo_lock uut (
    .clk(clk), .rst(rst), .new_i(new_i), .value_i(value_i),
    .load_en_i(load_en_i), .code_i(code_i), .open_o(open_o)
  );

  task automatic check(input bit got, input bit exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s open_o actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected open_o after the coming edge
  task automatic cyc(input bit r, input bit n, input logic [3:0] v,
                     input logic [2:0] le, input logic [3:0] cd,
                     input bit exp, input string tag);
    @(negedge clk);
    rst = r; new_i = n; value_i = v; load_en_i = le; code_i = cd;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic dig(input logic [3:0] v, input bit exp, input string tag);
    cyc(1'b0, 1'b1, v, 3'b000, 4'h0, exp, tag);
  endtask

  // monitor: compares just after each edge
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) check(open_o, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    n_checks++; n_fail++;
    $display("FAIL watchdog open_o actual=x expected=done");
    summary();
  end

  initial begin
    cyc(1'b1, 1'b0, 4'h0, 3'b000, 4'h0, 1'b0, "R1 reset closed");
    // R7 load code 3,7,9 one digit at a time
    cyc(1'b1, 1'b0, 4'h0, 3'b001, 4'h3, 1'b0, "R7 load d0");
    cyc(1'b1, 1'b0, 4'h0, 3'b010, 4'h7, 1'b0, "R7 load d1");
    cyc(1'b1, 1'b0, 4'h0, 3'b100, 4'h9, 1'b0, "R7 load d2");
    cyc(1'b0, 1'b0, 4'h3, 3'b000, 4'h0, 1'b0, "R4 idle");
    dig(4'h3, 1'b0, "R2 step0 match");
    cyc(1'b0, 1'b0, 4'h9, 3'b000, 4'h0, 1'b0, "R4 idle value ignored");
    dig(4'h7, 1'b0, "R2 step1 match");
    cyc(1'b0, 1'b0, 4'h7, 3'b000, 4'h0, 1'b0, "R4 idle between");
    dig(4'h9, 1'b1, "R2 third match opens");
    // R8: probe before the edge once completing inputs are driven
    #1 check(open_o, 1'b0, "R8 no combinational open");
    dig(4'h0, 1'b1, "R5 open after wrong digit");
    dig(4'h9, 1'b1, "R5 open after digit");
    cyc(1'b0, 1'b0, 4'h5, 3'b000, 4'h0, 1'b1, "R8 input change keeps open");
    // R1 reset keeps code
    cyc(1'b1, 1'b0, 4'h0, 3'b000, 4'h0, 1'b0, "R1 reset closes");
    dig(4'h3, 1'b0, "R1 code kept d0");
    dig(4'h7, 1'b0, "R1 code kept d1");
    dig(4'h9, 1'b1, "R1 code kept opens");
    // R3 wrong at step 0, then R6
    cyc(1'b1, 1'b0, 4'h0, 3'b000, 4'h0, 1'b0, "R1 reset");
    dig(4'h5, 1'b0, "R3 miss step0");
    dig(4'h3, 1'b0, "R6 err d0");
    dig(4'h7, 1'b0, "R6 err d1");
    dig(4'h9, 1'b0, "R6 err full code stays closed");
    // R3 wrong at step 1
    cyc(1'b1, 1'b0, 4'h0, 3'b000, 4'h0, 1'b0, "R1 reset");
    dig(4'h3, 1'b0, "R2 step0");
    dig(4'h8, 1'b0, "R3 miss step1");
    dig(4'h9, 1'b0, "R6 err after miss step1");
    // R3 wrong at step 2
    cyc(1'b1, 1'b0, 4'h0, 3'b000, 4'h0, 1'b0, "R1 reset");
    dig(4'h3, 1'b0, "R2 step0");
    dig(4'h7, 1'b0, "R2 step1");
    dig(4'h1, 1'b0, "R3 miss step2");
    dig(4'h9, 1'b0, "R6 err after miss step2");
    // R7 write d0 to 5 while entering old d0, then d1 to 4
    cyc(1'b1, 1'b0, 4'h0, 3'b000, 4'h0, 1'b0, "R1 reset");
    cyc(1'b0, 1'b1, 4'h3, 3'b001, 4'h5, 1'b0, "R7 same-cycle uses old digit");
    cyc(1'b0, 1'b0, 4'h0, 3'b010, 4'h4, 1'b0, "R7 load d1 while checking");
    dig(4'h4, 1'b0, "R7 new d1 matches");
    dig(4'h9, 1'b1, "R7 d2 untouched opens");
    cyc(1'b1, 1'b0, 4'h0, 3'b000, 4'h0, 1'b0, "R1 reset");
    dig(4'h5, 1'b0, "R7 new d0 matches");
    dig(4'h4, 1'b0, "R7 d1");
    dig(4'h9, 1'b1, "R7 full new code opens");
    cyc(1'b1, 1'b0, 4'h0, 3'b000, 4'h0, 1'b0, "R1 reset");
    dig(4'h3, 1'b0, "R3 old d0 now wrong");
    dig(4'h5, 1'b0, "R6 stays closed");
    cyc(1'b0, 1'b0, 4'h0, 3'b000, 4'h0, 1'b0, "R4 final idle");
    @(posedge clk); @(posedge clk); #6;
    summary();
  end
endmodule